// File: doc/BRIEF.md
# Memory-Mapped Serial Transmitter with Transmit Queue

This block is a serial transmit port that sits on a simple register bus. Software picks a bit rate, turns the transmitter on and writes characters one at a time into a data register. Each character goes into a 16-entry queue. A shifter takes characters from the queue and sends each one on a single output line as an asynchronous frame. The frame has one low start bit, eight data bits with the least significant bit first, and one high stop bit. The line stays high when there is nothing to send.

Software learns the state of the transmitter by polling two sticky status flags. One flag says the queue is empty. The other says the queue is empty and the line has gone back to idle after a stop bit. Software clears a flag by writing 0 to its bit; writing 1 to a flag bit leaves it unchanged. A queue-flush bit and the enable bits let a driver start from a clean state. A few receive-side flag bits and the receive enable and flush bits exist only so that such a driver can write them and read them back. No receive path is attached to them.

The bus is a single-cycle interface with a select, a write strobe and a size bit (byte or halfword). Reads are combinational.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is high, the status register (offset 0x8) reads 0x0060, and the control (0x4), queue-control (0xC) and line-status (0x12) registers read 0.
- R2: Each register accepts only writes of its own size. The rate register (0x2), the data register (0x6) and the extended register (0x14) are byte registers. All other registers are halfword registers. A write of the wrong size changes nothing.
- R3: The frame is one low start bit, then data bits 0 to 7, then one high stop bit. When no frame is in progress the line is high.
- R4: Every bit on the line lasts exactly 32 × (rate + 1) clock cycles, where rate is the value of the rate register.
- R5: The queue holds 16 characters and sends them in the order they were written. A data write while the queue is full is dropped.
- R6: No frame starts while control bit 5 (transmit enable) is 0. Queued characters begin to send once the bit is set.
- R7: While queue-control bit 2 is 1, the transmit queue is empty, data writes are dropped and no frame starts. Writing 0 to the bit releases the flush.
- R8: Status bit 5 is set in every cycle in which the queue is empty. Writing 0 to the bit clears it only while the queue holds data. Writing 1 to it has no effect.
- R9: Status bit 6 is set whenever the queue is empty and the shifter is idle, so it sets again after the stop bit of the last frame has been sent. It is cleared by writing 0 in the same way as bit 5.
- R10: When bit 4 of the extended register is 1, offset 0x2 no longer reaches the rate register. Byte writes there are ignored and reads return 0. When the bit is cleared, the stored rate is visible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busHalf | input | 1 | 1 for a halfword access, 0 for a byte access |
| busAddr | input | 5 | Byte offset of the register |
| busWData | input | 16 | Write data; byte writes use bits 7:0 |
| busRData | output | 16 | Read data, zero-extended, valid while a read is selected |
| txLine | output | 1 | Serial output line, high when idle |

## Verification
Several properties are checked in every cycle by assertions:
- The line is high whenever the shifter is idle.
- The queue never holds more than its depth, and a push while the queue is full leaves the fill level unchanged.
- A disabled transmitter never leaves the idle state.
- A flushed queue is empty in the next cycle.
- The empty flag and the end flag follow the conditions that set them.
- A rate write of the wrong size does not change the rate register.

Some behaviour can only be shown by the bench scenarios, which decode frames on the line against a queue of expected characters:
- the bit order and the framing;
- the exact bit length at two rate settings;
- ordering and dropping with a full queue;
- the timing of the end flag around a frame;
- the rate-register diversion by the extended register.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int RATE_W = 8;

  localparam logic [ADDR_W-1:0] OFS_MODE    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_RATE    = 5'h02;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TXDATA  = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_FIFOCTL = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_LINE    = 5'h12;
  localparam logic [ADDR_W-1:0] OFS_EXT     = 5'h14;

  localparam int CTRL_RXEN  = 4;
  localparam int CTRL_TXEN  = 5;
  localparam int FCTL_RXRST = 1;
  localparam int FCTL_TXRST = 2;
  localparam int ST_RXERR   = 7;
  localparam int ST_TEND    = 6;
  localparam int ST_TDFE    = 5;
  localparam int ST_BRK     = 4;
  localparam int ST_RDY     = 0;
  localparam int LS_OVR     = 0;
  localparam int EXT_SEL    = 4;

  // control -> datapath strobes and settings
  typedef struct packed {
    logic              push;
    logic [DATA_W-1:0] pushData;
    logic              txEnable;
    logic              txFifoRst;
    logic [RATE_W-1:0] rate;
  } txCmd_t;

  // datapath -> control condition signals
  typedef struct packed {
    logic fifoEmpty;
    logic fifoFull;
    logic shifterIdle;
  } txStat_t;
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic              busHalf,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWData,
  output logic [15:0]       busRData,
  output txCmd_t            cmd,
  input  txStat_t           stat
);
  logic wrByte, wrHalf, rateVisible, statWr, lineWr;
  logic [15:0]       modeReg;
  logic [RATE_W-1:0] rateReg;
  logic [7:0]        extReg;
  logic txEn, rxEn, txRst, rxRst;
  logic tend, tdfe, rxErr, brk, rdy, ovr;

  assign wrByte      = busSel & busWrite & ~busHalf;
  assign wrHalf      = busSel & busWrite & busHalf;
  assign rateVisible = ~extReg[EXT_SEL];
  assign statWr      = wrHalf & (busAddr == OFS_STAT);
  assign lineWr      = wrHalf & (busAddr == OFS_LINE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      rateReg <= '0;
      extReg  <= '0;
      txEn    <= 1'b0;
      rxEn    <= 1'b0;
      txRst   <= 1'b0;
      rxRst   <= 1'b0;
    end else begin
      if (wrHalf && busAddr == OFS_MODE) modeReg <= busWData;
      if (wrByte && busAddr == OFS_RATE && rateVisible) rateReg <= busWData[RATE_W-1:0];
      if (wrByte && busAddr == OFS_EXT) extReg <= busWData[7:0];
      if (wrHalf && busAddr == OFS_CTRL) begin
        txEn <= busWData[CTRL_TXEN];
        rxEn <= busWData[CTRL_RXEN];
      end
      if (wrHalf && busAddr == OFS_FIFOCTL) begin
        txRst <= busWData[FCTL_TXRST];
        rxRst <= busWData[FCTL_RXRST];
      end
    end
  end

  // sticky flags: set by condition, cleared only by writing 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tend  <= 1'b1;
      tdfe  <= 1'b1;
      rxErr <= 1'b0;
      brk   <= 1'b0;
      rdy   <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      tdfe  <= stat.fifoEmpty | (tdfe & ~(statWr & ~busWData[ST_TDFE]));
      tend  <= (stat.fifoEmpty & stat.shifterIdle) |
               (tend & ~(statWr & ~busWData[ST_TEND]));
      rxErr <= rxErr & ~(statWr & ~busWData[ST_RXERR]);
      brk   <= brk & ~(statWr & ~busWData[ST_BRK]);
      rdy   <= rdy & ~(statWr & ~busWData[ST_RDY]);
      ovr   <= ovr & ~(lineWr & ~busWData[LS_OVR]);
    end
  end

  always_comb begin
    busRData = '0;
    if (busSel && !busWrite) begin
      unique case (busAddr)
        OFS_MODE:    busRData = modeReg;
        OFS_RATE:    busRData = rateVisible ? 16'(rateReg) : 16'h0;
        OFS_CTRL:    busRData = 16'((txEn << CTRL_TXEN) | (rxEn << CTRL_RXEN));
        OFS_STAT:    busRData = 16'((rxErr << ST_RXERR) | (tend << ST_TEND) |
                                    (tdfe << ST_TDFE) | (brk << ST_BRK) | (rdy << ST_RDY));
        OFS_FIFOCTL: busRData = 16'((txRst << FCTL_TXRST) | (rxRst << FCTL_RXRST));
        OFS_LINE:    busRData = 16'(ovr << LS_OVR);
        OFS_EXT:     busRData = 16'(extReg);
        default:     busRData = '0;
      endcase
    end
  end

  assign cmd.push      = wrByte & (busAddr == OFS_TXDATA);
  assign cmd.pushData  = busWData[DATA_W-1:0];
  assign cmd.txEnable  = txEn;
  assign cmd.txFifoRst = txRst;
  assign cmd.rate      = rateReg;

  // R8: an empty queue raises the empty flag in the next cycle
  assert_tdfe_follows_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    stat.fifoEmpty |=> tdfe);
  // R9: empty queue with idle shifter raises the end flag
  assert_tend_follows_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stat.fifoEmpty && stat.shifterIdle) |=> tend);
  // R2: a halfword write to the byte-wide rate register is ignored
  assert_rate_size_guard_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrHalf && busAddr == OFS_RATE) |=> $stable(rateReg));
endmodule

// File: rtl/sertx_datapath.sv
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int BIT_UNIT = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  txCmd_t cmd,
  output txStat_t stat,
  output logic   txLine
);
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int SUB_W   = (BIT_UNIT > 1) ? $clog2(BIT_UNIT) : 1;
  localparam int FRAME_N = DATA_W + 2;
  localparam int LEFT_W  = $clog2(FRAME_N + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              empty, full, pushOk, canStart;

  logic [DATA_W:0]   frameBits;
  logic [LEFT_W-1:0] bitsLeft;
  logic [SUB_W-1:0]  subCnt;
  logic [RATE_W-1:0] divCnt;
  logic              busy, subEnd, bitTick, lastTick;

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign busy     = (bitsLeft != '0);
  assign subEnd   = (subCnt == SUB_W'(BIT_UNIT - 1));
  assign bitTick  = busy & subEnd & (divCnt >= cmd.rate);
  assign lastTick = bitTick & (bitsLeft == LEFT_W'(1));
  assign pushOk   = cmd.push & ~full & ~cmd.txFifoRst;
  assign canStart = cmd.txEnable & ~cmd.txFifoRst & ~empty & (~busy | lastTick);

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= cmd.pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (cmd.txFifoRst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk)   wrPtr <= nextPtr(wrPtr);
      if (canStart) rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(pushOk) - CNT_W'(canStart);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameBits <= '1;
      bitsLeft  <= '0;
      subCnt    <= '0;
      divCnt    <= '0;
      txLine    <= 1'b1;
    end else if (canStart) begin
      frameBits <= {1'b1, mem[rdPtr]};
      bitsLeft  <= LEFT_W'(FRAME_N);
      subCnt    <= '0;
      divCnt    <= '0;
      txLine    <= 1'b0;
    end else if (bitTick) begin
      bitsLeft  <= bitsLeft - 1'b1;
      subCnt    <= '0;
      divCnt    <= '0;
      txLine    <= frameBits[0];
      frameBits <= {1'b1, frameBits[DATA_W:1]};
    end else if (busy) begin
      if (subEnd) begin
        subCnt <= '0;
        divCnt <= divCnt + 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  assign stat.fifoEmpty   = empty;
  assign stat.fifoFull    = full;
  assign stat.shifterIdle = ~busy;

  // R3: line idles high
  assert_idle_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);
  // R5: fill level bounded by depth
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R5: push into a full queue without a pop leaves it full
  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (full && cmd.push && !canStart && !cmd.txFifoRst) |=> (count == CNT_W'(DEPTH)));
  // R6: a disabled transmitter stays idle
  assert_no_start_disabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.txEnable && !busy) |=> !busy);
  // R7: flush empties the queue
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.txFifoRst |=> (count == '0));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int BIT_UNIT = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic        busHalf,
  input  logic [4:0]  busAddr,
  input  logic [15:0] busWData,
  output logic [15:0] busRData,
  output logic        txLine
);
  txCmd_t  cmd;
  txStat_t stat;

  sertx_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busHalf(busHalf),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData), .cmd(cmd), .stat(stat)
  );

  sertx_datapath #(.DEPTH(DEPTH), .BIT_UNIT(BIT_UNIT)) i_datapath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .stat(stat), .txLine(txLine)
  );
endmodule

// File: tb/test_sertx_top.sv
module test_sertx_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0, busHalf = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [15:0] busWData = '0;
  logic [15:0] busRData;
  logic        txLine;

  int nChecks = 0, nFail = 0;
  int bitP = 32;
  int frameCount = 0;
  int lowCnt = 0, lastLowRun = 0;
  logic [7:0] expQ[$];

  always #2.5 clk = ~clk;

  sertx_top i_sertx_top (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busHalf(busHalf),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData), .txLine(txLine)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] a, input logic [15:0] d, input logic half);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busHalf = half; busAddr = a; busWData = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busHalf = 1'b1; busAddr = a;
    #1 d = busRData;
    busSel = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] v;
    busRd(a, v);
    chk(tag, 32'(v), 32'(exp));
  endtask

  // driver: data write, expected character queued when it should be accepted
  task automatic sendByte(input logic [7:0] b, input bit accepted);
    busWr(5'h06, {8'h00, b}, 1'b0);
    if (accepted) expQ.push_back(b);
  endtask

  task automatic drain(input string tag);
    int t = 0;
    while (expQ.size() != 0 && t < 40000) begin
      @(negedge clk);
      t++;
    end
    repeat (bitP * 2) @(negedge clk);
    chk(tag, 32'(expQ.size()), 32'd0);
  endtask

  // low-run measurement on the line
  always @(negedge clk) begin
    if (txLine === 1'b0) lowCnt++;
    else begin
      if (lowCnt != 0) lastLowRun = lowCnt;
      lowCnt = 0;
    end
  end

  // monitor: decode frames, compare with scoreboard queue
  initial begin
    logic [7:0] rx;
    wait (rstN);
    forever begin
      @(negedge clk);
      if (txLine === 1'b0) begin
        repeat (bitP / 2) @(negedge clk);
        chk("R3 start bit low", 32'(txLine), 32'd0);
        for (int i = 0; i < 8; i++) begin
          repeat (bitP) @(negedge clk);
          rx[i] = txLine;
        end
        repeat (bitP) @(negedge clk);
        chk("R3 stop bit high", 32'(txLine), 32'd1);
        frameCount++;
        if (expQ.size() == 0) begin
          nChecks++;
          nFail++;
          $display("FAIL R3 unexpected frame: got %0h expected none", rx);
        end else begin
          chk("R3 frame data", 32'(rx), 32'(expQ.pop_front()));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int fc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 line idle", 32'(txLine), 32'd1);
    rdChk("R1 status", 5'h08, 16'h0060);
    rdChk("R1 control", 5'h04, 16'h0000);
    rdChk("R1 queue control", 5'h0C, 16'h0000);
    rdChk("R1 line status", 5'h12, 16'h0000);

    // driver-style initialisation
    busWr(5'h04, 16'h0000, 1'b1);
    busWr(5'h0C, 16'h0006, 1'b1);
    busWr(5'h08, 16'h0000, 1'b1);
    busWr(5'h12, 16'h0000, 1'b1);
    busWr(5'h00, 16'h0000, 1'b1);
    busWr(5'h14, 16'h0000, 1'b0);
    busWr(5'h02, 16'h0000, 1'b0);
    busWr(5'h0C, 16'h0000, 1'b1);
    busWr(5'h04, 16'h0030, 1'b1);
    rdChk("R8 flags reassert on empty queue", 5'h08, 16'h0060);
    rdChk("R6 control enable readback", 5'h04, 16'h0030);

    // R3 several patterns, rate 0
    bitP = 32;
    sendByte(8'hA5, 1); sendByte(8'h3C, 1); sendByte(8'h01, 1); sendByte(8'h80, 1);
    drain("R3 all frames seen");
    rdChk("R9 end flag after last stop", 5'h08, 16'h0060);

    // R2 size rules
    busWr(5'h02, 16'h0007, 1'b1);
    rdChk("R2 halfword write to rate ignored", 5'h02, 16'h0000);
    busWr(5'h04, 16'h0000, 1'b0);
    rdChk("R2 byte write to control ignored", 5'h04, 16'h0030);
    busWr(5'h00, 16'h1234, 1'b1);
    rdChk("R2 mode halfword write", 5'h00, 16'h1234);
    busWr(5'h00, 16'h0000, 1'b1);
    busWr(5'h02, 16'h0002, 1'b0);
    rdChk("R2 byte write to rate", 5'h02, 16'h0002);

    // R4 bit period at rate 2
    bitP = 96;
    sendByte(8'h00, 1);
    drain("R4 frame seen");
    chk("R4 low run of 0x00 frame", 32'(lastLowRun), 32'(9 * 96));
    sendByte(8'h55, 1);
    drain("R4 alternating frame seen");
    chk("R4 single bit width", 32'(lastLowRun), 32'(96));

    // R10 extended select diverts rate offset
    busWr(5'h14, 16'h0010, 1'b0);
    busWr(5'h02, 16'h0009, 1'b0);
    rdChk("R10 rate hidden", 5'h02, 16'h0000);
    busWr(5'h14, 16'h0000, 1'b0);
    rdChk("R10 rate unchanged", 5'h02, 16'h0002);
    busWr(5'h02, 16'h0000, 1'b0);
    bitP = 32;

    // R6 and R8/R9 flag behaviour
    busWr(5'h04, 16'h0000, 1'b1);
    fc = frameCount;
    sendByte(8'h11, 1);
    repeat (300) @(negedge clk);
    chk("R6 no frame while disabled", 32'(frameCount - fc), 32'd0);
    chk("R6 line stays high", 32'(txLine), 32'd1);
    rdChk("R8 flags sticky after write", 5'h08, 16'h0060);
    busWr(5'h08, 16'h00FF, 1'b1);
    rdChk("R8 writing ones no effect", 5'h08, 16'h0060);
    busWr(5'h08, 16'h0000, 1'b1);
    rdChk("R8 R9 cleared while data queued", 5'h08, 16'h0000);
    busWr(5'h04, 16'h0030, 1'b1);
    repeat (10) @(negedge clk);
    rdChk("R9 end flag clear mid-frame, R8 empty set", 5'h08, 16'h0020);
    drain("R6 frame after enable");
    rdChk("R9 end flag set after frame", 5'h08, 16'h0060);

    // R5 depth and drop
    busWr(5'h04, 16'h0000, 1'b1);
    fc = frameCount;
    for (int i = 0; i < 17; i++) sendByte(8'(i * 7 + 3), i < 16);
    busWr(5'h04, 16'h0030, 1'b1);
    drain("R5 sixteen frames in order");
    chk("R5 frame count", 32'(frameCount - fc), 32'd16);

    // R7 flush
    busWr(5'h04, 16'h0000, 1'b1);
    sendByte(8'h21, 0); sendByte(8'h22, 0); sendByte(8'h23, 0);
    busWr(5'h08, 16'h0000, 1'b1);
    rdChk("R7 flags cleared before flush", 5'h08, 16'h0000);
    busWr(5'h0C, 16'h0004, 1'b1);
    rdChk("R7 flush bit readback", 5'h0C, 16'h0004);
    rdChk("R7 empty after flush", 5'h08, 16'h0060);
    sendByte(8'h24, 0);
    busWr(5'h04, 16'h0030, 1'b1);
    repeat (100) @(negedge clk);
    busWr(5'h0C, 16'h0000, 1'b1);
    fc = frameCount;
    repeat (400) @(negedge clk);
    chk("R7 nothing sent after flush", 32'(frameCount - fc), 32'd0);
    chk("R7 line idle", 32'(txLine), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule